// File: doc/BRIEF.md
# Multi-format audio serial receiver

This block takes a stereo audio stream carried on three wires (bit clock, left/right clock and serial data) and turns it into parallel 24-bit sample pairs. All three wires are oversampled by the core clock through a short synchronizer. Data bits are taken on each rising edge of the bit clock. One deframer handles every supported framing. It counts bit positions from each left/right clock transition and produces one finished word per channel half.

Right-justified framings keep the last N bits seen before the next transition, with N set to 16, 20 or 24. I2S and left-justified framings keep the 24 bits that start at the MSB position. Words narrower than 24 bits are placed at the top of the output word, with zeros below them. The right-justified 16-bit setting also covers the packed stream, which has 32 bit clocks per frame.

Completed pairs leave the block on a valid/ready output. Audio cannot be stalled at its source, so back-pressure never slows the input. If a new pair completes while the previous pair is still waiting, the new pair replaces it and the older pair is lost. Each channel also has a silence flag, raised after a long run of zero words.

Top module: `aud_serial_rx`

## Requirements
- R1: The framing is chosen by `mode_code_i` and `lj_en_i`. Codes 00, 10 and 11 select right-justified 16-, 20- and 24-bit words, and code 01 selects I2S. When `lj_en_i` is 1, it overrides the code and selects left-justified. Bits are two's complement and MSB first, and each is taken at a bit-clock rising edge.
- R2: In right- and left-justified framings, a high left/right clock marks the left channel. In I2S, a low left/right clock marks the left channel. A pair is built only from a left word followed by the right word that comes after it.
- R3: In right-justified framings, the word is the last N bits received before a left/right clock transition. Bits received earlier in that half have no effect. The word appears in bits 23 down to 24-N of the output, with zeros below.
- R4: In I2S, the MSB is the bit one bit-clock after the transition, and the 24 bits starting there form the word.
- R5: In left-justified framing, the MSB is the first bit after the transition, and the 24 bits starting there form the word.
- R6: With 32 bit clocks per frame in right-justified 16-bit mode, each 16-bit half is received in full (packed stream).
- R7: `out_valid_o` rises once per frame, after the right word has completed. The partial half seen before the first transition after reset produces nothing.
- R8: `out_valid_o` stays high until a cycle in which `out_ready_i` is 1. While it waits, the data stays stable unless a new pair completes. A new pair replaces the waiting one.
- R9: A channel's zero flag goes high when that channel receives its 1025th consecutive all-zero word.
- R10: A channel's zero flag clears on that channel's first nonzero word. The other channel's flag is not affected.
- R11: While reset is active and directly after it, `out_valid_o` and both zero flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that oversamples the serial wires |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | Serial bit clock |
| lrclk_i | input | 1 | Left/right channel clock |
| sdata_i | input | 1 | Serial audio data |
| mode_code_i | input | 2 | Framing code (see R1) |
| lj_en_i | input | 1 | Selects left-justified framing, overriding the code |
| out_valid_o | output | 1 | A sample pair is available |
| out_ready_i | input | 1 | The consumer takes the pair in this cycle |
| out_left_o | output | 24 | Left sample, MSB-aligned |
| out_right_o | output | 24 | Right sample, MSB-aligned |
| zero_left_o | output | 1 | Left channel silence flag |
| zero_right_o | output | 1 | Right channel silence flag |

## Verification
Several rules are checked by assertions on every cycle:
- the output pair holds while it waits for ready;
- a valid rise always follows a finished right word;
- a zero flag rises only after a zero word of its own channel;
- a nonzero word always clears its channel's flag.

Other behaviour can only be shown by the bench's scenarios. These cover where the MSB falls in each framing, the polarity of the left/right clock, the bits ignored before a right-justified word, the packed stream, and the exact 1025-word threshold of the silence flag.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;
  typedef enum logic [2:0] {
    FMT_RJ16 = 3'd0,
    FMT_I2S  = 3'd1,
    FMT_RJ20 = 3'd2,
    FMT_RJ24 = 3'd3,
    FMT_LJ   = 3'd4
  } fmt_e;

  localparam int SAMPLE_W = 24;
  localparam int RJ16_W   = 16;
  localparam int RJ20_W   = 20;
endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic lrclk_i,
  input  logic sdata_i,
  output logic bit_stb,
  output logic lr_s,
  output logic sd_s
);
  logic [2:0] stage [STAGES];
  logic       bclk_d;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) stage[g] <= '0;
        else if (g == 0) stage[g] <= {sdata_i, lrclk_i, bclk_i};
        else stage[g] <= stage[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) bclk_d <= 1'b0;
    else bclk_d <= stage[STAGES-1][0];
  end

  assign bit_stb = stage[STAGES-1][0] & ~bclk_d;
  assign lr_s    = stage[STAGES-1][1];
  assign sd_s    = stage[STAGES-1][2];
endmodule

// File: rtl/aud_rx_deframe.sv
module aud_rx_deframe
  import aud_rx_pkg::*;
#(
  parameter int W     = SAMPLE_W,
  parameter int CNT_W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  fmt_e         fmt,
  input  logic         bit_stb,
  input  logic         lr,
  input  logic         sd,
  output logic         word_stb,
  output logic         word_left,
  output logic [W-1:0] word
);
  localparam int KW = $clog2(W + 1);

  logic             seen, armed, prev_ch;
  logic [CNT_W-1:0] cnt;
  logic [W-1:0]     sh, cap;
  logic [KW-1:0]    k;
  logic             ch, edge_now, is_rj;
  logic [CNT_W-1:0] pos, off;
  logic [W-1:0]     rj_word;

  always_comb begin
    ch       = (fmt == FMT_I2S) ? ~lr : lr;
    edge_now = seen && (ch != prev_ch);
    pos      = edge_now ? '0 : cnt;
    off      = (fmt == FMT_I2S) ? CNT_W'(1) : '0;
    is_rj    = (fmt == FMT_RJ16) || (fmt == FMT_RJ20) || (fmt == FMT_RJ24);
    case (fmt)
      FMT_RJ16: rj_word = {sh[RJ16_W-1:0], {(W-RJ16_W){1'b0}}};
      FMT_RJ20: rj_word = {sh[RJ20_W-1:0], {(W-RJ20_W){1'b0}}};
      default:  rj_word = sh;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen      <= 1'b0;
      armed     <= 1'b0;
      prev_ch   <= 1'b0;
      cnt       <= '0;
      sh        <= '0;
      cap       <= '0;
      k         <= '0;
      word_stb  <= 1'b0;
      word_left <= 1'b0;
      word      <= '0;
    end else begin
      word_stb <= 1'b0;
      if (bit_stb) begin
        sh      <= {sh[W-2:0], sd};
        seen    <= 1'b1;
        prev_ch <= ch;
        if (edge_now) begin
          armed <= 1'b1;
          cnt   <= CNT_W'(1);
          if (armed) begin
            word_stb  <= 1'b1;
            word_left <= prev_ch;
            word      <= is_rj ? rj_word : cap;
          end
        end else if (cnt != '1) begin
          cnt <= cnt + 1'b1;
        end
        if (pos == off) begin
          cap <= {sd, {(W-1){1'b0}}};
          k   <= KW'(1);
        end else if ((pos > off) && (int'(k) < W)) begin
          cap[W-1-int'(k)] <= sd;
          k                <= k + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/aud_rx_zero.sv
module aud_rx_zero #(
  parameter int RUN = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic is_zero,
  output logic flag
);
  localparam int CW = $clog2(RUN + 2);
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) run_cnt <= '0;
    else if (stb) begin
      if (!is_zero) run_cnt <= '0;
      else if (run_cnt <= CW'(RUN)) run_cnt <= run_cnt + 1'b1;
    end
  end

  assign flag = (run_cnt > CW'(RUN));
endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
  import aud_rx_pkg::*;
#(
  parameter int W        = SAMPLE_W,
  parameter int SYNC_STG = 2,
  parameter int ZERO_RUN = 1024
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bclk_i,
  input  logic         lrclk_i,
  input  logic         sdata_i,
  input  logic [1:0]   mode_code_i,
  input  logic         lj_en_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] out_left_o,
  output logic [W-1:0] out_right_o,
  output logic         zero_left_o,
  output logic         zero_right_o
);
  fmt_e         fmt;
  logic         bit_stb, lr_s, sd_s;
  logic         w_stb, w_left;
  logic [W-1:0] w_data;
  logic [W-1:0] left_hold;
  logic         left_ok;
  logic [1:0]   zflag;

  assign fmt = lj_en_i ? FMT_LJ : fmt_e'({1'b0, mode_code_i});

  aud_rx_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .lrclk_i(lrclk_i),
    .sdata_i(sdata_i), .bit_stb(bit_stb), .lr_s(lr_s), .sd_s(sd_s)
  );

  aud_rx_deframe #(.W(W)) u_deframe (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .bit_stb(bit_stb), .lr(lr_s),
    .sd(sd_s), .word_stb(w_stb), .word_left(w_left), .word(w_data)
  );

  genvar c;
  generate
    for (c = 0; c < 2; c++) begin : g_zero
      aud_rx_zero #(.RUN(ZERO_RUN)) u_zero (
        .clk(clk), .rst_n(rst_n),
        .stb(w_stb && (w_left == (c == 0))),
        .is_zero(w_data == '0),
        .flag(zflag[c])
      );
    end
  endgenerate

  assign zero_left_o  = zflag[0];
  assign zero_right_o = zflag[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_hold   <= '0;
      left_ok     <= 1'b0;
      out_valid_o <= 1'b0;
      out_left_o  <= '0;
      out_right_o <= '0;
    end else begin
      if (w_stb && w_left) begin
        left_hold <= w_data;
        left_ok   <= 1'b1;
      end
      if (w_stb && !w_left && left_ok) begin
        out_left_o  <= left_hold;
        out_right_o <= w_data;
        out_valid_o <= 1'b1;
        left_ok     <= 1'b0;
      end else if (out_valid_o && out_ready_i) begin
        out_valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/aud_serial_rx_chk.sv
module aud_serial_rx_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         out_valid_o,
  input logic         out_ready_i,
  input logic [W-1:0] out_left_o,
  input logic [W-1:0] out_right_o,
  input logic         zero_left_o,
  input logic         zero_right_o,
  input logic         w_stb,
  input logic         w_left,
  input logic [W-1:0] w_data
);
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i |=> out_valid_o); // R8

  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i && !(w_stb && !w_left)
      |=> $stable(out_left_o) && $stable(out_right_o)); // R8

  AST_VALID_AFTER_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid_o) |-> $past(w_stb && !w_left)); // R7

  AST_ZL_RISE_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zero_left_o) |-> $past(w_stb && w_left && (w_data == '0))); // R9

  AST_ZR_RISE_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zero_right_o) |-> $past(w_stb && !w_left && (w_data == '0))); // R9

  AST_ZL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    w_stb && w_left && (w_data != '0) |=> !zero_left_o); // R10

  AST_ZR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    w_stb && !w_left && (w_data != '0) |=> !zero_right_o); // R10
endmodule

bind aud_serial_rx aud_serial_rx_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
  .out_left_o(out_left_o), .out_right_o(out_right_o),
  .zero_left_o(zero_left_o), .zero_right_o(zero_right_o),
  .w_stb(w_stb), .w_left(w_left), .w_data(w_data)
);

// File: tb/aud_serial_rx_bench.sv
`timescale 1ns/1ps
module aud_serial_rx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
  logic [1:0]  mode_code = 2'b00;
  logic        lj_en = 1'b0;
  logic        out_valid, out_ready = 1'b1;
  logic [23:0] out_left, out_right;
  logic        zero_left, zero_right;

  int n_chk = 0, n_fail = 0;
  int hp = 2;
  int fmt_cur = 0;
  bit auto_cmp = 1'b1;
  bit push_en = 1'b1;
  string cur_req = "R3";
  string zreq = "R9";
  logic [23:0] exp_l[$], exp_r[$];
  bit exp_zl[$], exp_zr[$];
  int zc_l = 0, zc_r = 0;

  always #10 clk = ~clk;

  aud_serial_rx u_aud_serial_rx (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .lrclk_i(lrclk), .sdata_i(sdata),
    .mode_code_i(mode_code), .lj_en_i(lj_en), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_left_o(out_left), .out_right_o(out_right),
    .zero_left_o(zero_left), .zero_right_o(zero_right)
  );

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  always begin
    @(negedge clk);
    #1;
    if (rst_n && auto_cmp && out_valid && out_ready) begin
      if (exp_l.size() == 0) begin
        chk("R7", "unexpected pair", 32'd1, 32'd0);
      end else begin
        chk(cur_req, "left", {8'd0, out_left}, {8'd0, exp_l.pop_front()});
        chk(cur_req, "right", {8'd0, out_right}, {8'd0, exp_r.pop_front()});
        chk(zreq, "zero_left", {31'd0, zero_left}, {31'd0, exp_zl.pop_front()});
        chk(zreq, "zero_right", {31'd0, zero_right}, {31'd0, exp_zr.pop_front()});
      end
    end
  end

  task automatic drive_bit(logic lr, logic b);
    @(negedge clk);
    bclk = 1'b0; lrclk = lr; sdata = b;
    repeat (hp - 1) @(negedge clk);
    @(negedge clk);
    bclk = 1'b1;
    repeat (hp - 1) @(negedge clk);
  endtask

  function automatic int width_of(int f);
    return (f == 0) ? 16 : (f == 2) ? 20 : 24;
  endfunction

  task automatic send_half(int hlen, logic lr, logic [23:0] word);
    int wd = width_of(fmt_cur);
    for (int p = 0; p < hlen; p++) begin
      logic b;
      if (fmt_cur == 1) b = (p >= 1 && p <= 24) ? word[24 - p] : 1'b0;
      else if (fmt_cur == 4) b = (p < 24) ? word[23 - p] : 1'b0;
      else b = (p >= hlen - wd) ? word[wd - 1 - (p - (hlen - wd))] : 1'b1;
      drive_bit(lr, b);
    end
  endtask

  function automatic logic [23:0] expect_word(logic [23:0] w);
    int wd = width_of(fmt_cur);
    if (fmt_cur == 1 || fmt_cur == 4) return w;
    return w << (24 - wd);
  endfunction

  function automatic logic left_level();
    return (fmt_cur == 1) ? 1'b0 : 1'b1;
  endfunction

  task automatic send_frame(int hlen, logic [23:0] l, logic [23:0] r);
    logic [23:0] el = expect_word(l);
    logic [23:0] er = expect_word(r);
    if (push_en) begin
      zc_l = (el == 0) ? zc_l + 1 : 0;
      zc_r = (er == 0) ? zc_r + 1 : 0;
      exp_l.push_back(el); exp_r.push_back(er);
      exp_zl.push_back(zc_l > 1024); exp_zr.push_back(zc_r > 1024);
    end
    send_half(hlen, left_level(), l);
    send_half(hlen, ~left_level(), r);
  endtask

  task automatic start(int f);
    fmt_cur = f;
    @(negedge clk);
    rst_n = 1'b0;
    lj_en = (f == 4);
    mode_code = (f == 4) ? 2'b01 : f[1:0];
    bclk = 1'b0; sdata = 1'b0; lrclk = ~left_level();
    zc_l = 0; zc_r = 0;
    repeat (4) @(negedge clk);
    #1;
    chk("R11", "valid in reset", {31'd0, out_valid}, 32'd0);
    chk("R11", "zero flags in reset", {30'd0, zero_left, zero_right}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    send_half(4, ~left_level(), 24'h0);
  endtask

  task automatic finish_scn();
    send_half(4, left_level(), 24'h0);
    repeat (10) @(negedge clk);
    chk("R7", "pairs outstanding", exp_l.size(), 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R3: right-justified 16 in 64-bit frames, junk ones before each MSB
    cur_req = "R3";
    start(0);
    send_frame(32, 24'hAB1234, 24'h00FFFF);
    send_frame(32, 24'h008000, 24'h007FFF);
    send_frame(32, 24'h000001, 24'h00A5C3);
    finish_scn();
    // R1: right-justified 20 and 24
    cur_req = "R1";
    start(2);
    send_frame(32, 24'h0FEDCB, 24'h080001);
    send_frame(32, 24'h012345, 24'h0FFFFF);
    finish_scn();
    start(3);
    send_frame(32, 24'h800000, 24'h7FFFFF);
    send_frame(32, 24'h123456, 24'hFEDCBA);
    finish_scn();
    // R4 R2: I2S, left on low clock, MSB delayed one bit
    cur_req = "R4";
    start(1);
    send_frame(32, 24'hC0FFEE, 24'h135791);
    send_frame(32, 24'h800001, 24'h000002);
    finish_scn();
    cur_req = "R2";
    start(1);
    send_frame(32, 24'h111111, 24'hEEEEEE);
    finish_scn();
    // R5: left-justified, code 01 overridden by lj_en
    cur_req = "R5";
    start(4);
    send_frame(32, 24'hDEADBE, 24'h24680A);
    send_frame(32, 24'h000100, 24'hFF0000);
    finish_scn();
    // R8: back-pressure, newer pair replaces the waiting one
    auto_cmp = 1'b0; push_en = 1'b0;
    start(4);
    out_ready = 1'b0;
    send_frame(32, 24'h111111, 24'h222222);
    send_frame(32, 24'h333333, 24'h444444);
    send_half(4, 1'b1, 24'h0);
    repeat (10) @(negedge clk);
    #1;
    chk("R8", "valid held", {31'd0, out_valid}, 32'd1);
    chk("R8", "newest left", {8'd0, out_left}, 32'h333333);
    chk("R8", "newest right", {8'd0, out_right}, 32'h444444);
    repeat (20) @(negedge clk);
    #1;
    chk("R8", "still held", {31'd0, out_valid}, 32'd1);
    chk("R8", "left stable", {8'd0, out_left}, 32'h333333);
    @(negedge clk); out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0;
    #1;
    chk("R8", "valid dropped after take", {31'd0, out_valid}, 32'd0);
    out_ready = 1'b1; auto_cmp = 1'b1; push_en = 1'b1;
    // R6 R9 R10: packed 32-bit frames, long silence
    hp = 1;
    cur_req = "R6";
    start(0);
    send_frame(16, 24'h00ABCD, 24'h001234);
    zreq = "R9";
    for (int i = 0; i < 1025; i++) send_frame(16, 24'h0, 24'h0);
    zreq = "R10";
    send_frame(16, 24'h000005, 24'h0);
    send_frame(16, 24'h0, 24'h008000);
    finish_scn();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule